// File: doc/BRIEF.md
# Controller Error Counter and Status Flags

This block keeps the receive and transmit error tallies of a fault-confined serial bus controller. The bit-level logic reports its events as one-cycle pulses: a receive error, a transmit error of any kind (missing acknowledge, malformed field or bit mismatch), a receiver overrun, a message received cleanly and a message sent cleanly. Each error pulse moves the matching counter up by one. Each clean completion moves it down by one. Both counters stop at their limits and do not wrap.

The counter values are compared against two fixed limits. The warning limit is 96 and the error-passive limit is 127. The results are reported as level flags that follow the counters. Three sticky flags record events until software clears them: an invalid message was received, an overrun occurred, and an error interrupt request is pending. Software clears them with a write-one-to-clear pulse vector. The cause of an interrupt is read from the individual flags.

All pins are plain control and status signals, with no data stream and no back-pressure. A synchronous reset clears everything.

Top module: `can_err_status`

## Requirements
- R1: While `rst` is high at a rising clock edge, both counters become 0 and every flag output becomes 0.
- R2: A `tx_err_i` pulse raises `tx_cnt_o` by exactly one, and an `rx_err_i` pulse raises `rx_cnt_o` by exactly one. The new value is visible after that clock edge.
- R3: A `tx_ok_i` pulse lowers `tx_cnt_o` by one, and an `rx_ok_i` pulse lowers `rx_cnt_o` by one. A counter at 0 stays at 0.
- R4: A counter at 255 stays at 255 when an error pulse arrives.
- R5: An error pulse and a success pulse for the same counter in the same cycle leave that counter unchanged.
- R6: `tx_warn_o` is high exactly when `tx_cnt_o` is greater than 96.
- R7: `rx_warn_o` is high exactly when `rx_cnt_o` is 96 or more.
- R8: `rx_passive_o` is high exactly when `rx_cnt_o` is greater than 127.
- R9: An `rx_err_i` pulse sets `invalid_o`, and an `rx_ovf_i` pulse sets `overrun_o`. Both flags then stay high until cleared.
- R10: `errif_o` is set in the cycle's edge by an `rx_err_i` pulse, by an `rx_ovf_i` pulse, or by the rising of any of `tx_warn_o`, `rx_warn_o` or `rx_passive_o`. It then stays high until cleared. A transmit error that crosses no limit does not set it.
- R11: `flag_clr_i` is a write-one-to-clear vector. Bit 0 clears `errif_o`, bit 1 clears `invalid_o` and bit 2 clears `overrun_o`. When a set and a clear for the same flag arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_err_i | input | 1 | Receive error pulse |
| tx_err_i | input | 1 | Transmit error pulse (ack, form or bit) |
| rx_ovf_i | input | 1 | Receiver overrun pulse |
| rx_ok_i | input | 1 | Clean reception pulse |
| tx_ok_i | input | 1 | Clean transmission pulse |
| flag_clr_i | input | 3 | Write-one-to-clear for errif, invalid, overrun |
| rx_cnt_o | output | 8 | Receive error count |
| tx_cnt_o | output | 8 | Transmit error count |
| rx_warn_o | output | 1 | Receive count at or above 96 |
| tx_warn_o | output | 1 | Transmit count above 96 |
| rx_passive_o | output | 1 | Receive count above 127 |
| invalid_o | output | 1 | Sticky invalid-message flag |
| overrun_o | output | 1 | Sticky overrun flag |
| errif_o | output | 1 | Sticky error interrupt request |

## Verification
Every counter fault shows on `rx_cnt_o` or `tx_cnt_o` one edge after the pulse that caused it. A wrong step, a wrap at 255 or a drop below 0 is therefore visible in the very next cycle. A wrong limit comparison shows only when a counter passes 96 or 127. The bench drives both counters through those values and up to the limits on purpose. A lost or misrouted sticky bit stays wrong until the next clear, so the flags are checked on every cycle against a model, and again after each clear.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int unsigned DEF_CNT_W    = 8;
  localparam int unsigned DEF_WARN_LVL = 96;
  localparam int unsigned DEF_PASS_LVL = 127;

  // bit positions in the write-one-to-clear vector
  typedef enum int unsigned {
    CLR_ERRIF   = 0,
    CLR_INVALID = 1,
    CLR_OVERRUN = 2
  } clr_bit_e;

  localparam int unsigned NUM_STICKY = 3;
endpackage

// File: rtl/can_err_sat_cnt.sv
module can_err_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_comb begin
    cnt_d = cnt_q;
    if (up && !down && cnt_q != TOP)
      cnt_d = cnt_q + 1'b1;
    else if (down && !up && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_err_cmp.sv
module can_err_cmp #(
  parameter int unsigned W         = 8,
  parameter int unsigned LIMIT     = 96,
  parameter bit          INCLUSIVE = 1'b0
) (
  input  logic [W-1:0] value,
  output logic         hit
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  generate
    if (INCLUSIVE) begin : g_ge
      assign hit = (value >= LIM);
    end else begin : g_gt
      assign hit = (value > LIM);
    end
  endgenerate
endmodule

// File: rtl/can_err_sticky.sv
module can_err_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)         q[i] <= 1'b0;
        else if (set[i]) q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_err_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned WARN_LVL = DEF_WARN_LVL,
  parameter int unsigned PASS_LVL = DEF_PASS_LVL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_err_i,
  input  logic             tx_err_i,
  input  logic             rx_ovf_i,
  input  logic             rx_ok_i,
  input  logic             tx_ok_i,
  input  logic [2:0]       flag_clr_i,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic [CNT_W-1:0] tx_cnt_o,
  output logic             rx_warn_o,
  output logic             tx_warn_o,
  output logic             rx_passive_o,
  output logic             invalid_o,
  output logic             overrun_o,
  output logic             errif_o
);
  logic [CNT_W-1:0] rx_d, tx_d;
  logic rx_warn_d, tx_warn_d, rx_pass_d;
  logic level_rise;
  logic [NUM_STICKY-1:0] st_set, st_q;

  can_err_sat_cnt #(.W(CNT_W)) u_rx_cnt (
    .clk(clk), .rst(rst), .up(rx_err_i), .down(rx_ok_i),
    .cnt_q(rx_cnt_o), .cnt_d(rx_d));

  can_err_sat_cnt #(.W(CNT_W)) u_tx_cnt (
    .clk(clk), .rst(rst), .up(tx_err_i), .down(tx_ok_i),
    .cnt_q(tx_cnt_o), .cnt_d(tx_d));

  // present-state levels (outputs)
  can_err_cmp #(.W(CNT_W), .LIMIT(WARN_LVL), .INCLUSIVE(1'b1)) u_rx_warn_q (
    .value(rx_cnt_o), .hit(rx_warn_o));
  can_err_cmp #(.W(CNT_W), .LIMIT(WARN_LVL), .INCLUSIVE(1'b0)) u_tx_warn_q (
    .value(tx_cnt_o), .hit(tx_warn_o));
  can_err_cmp #(.W(CNT_W), .LIMIT(PASS_LVL), .INCLUSIVE(1'b0)) u_rx_pass_q (
    .value(rx_cnt_o), .hit(rx_passive_o));

  // next-state levels, used to spot a crossing at the same edge
  can_err_cmp #(.W(CNT_W), .LIMIT(WARN_LVL), .INCLUSIVE(1'b1)) u_rx_warn_d (
    .value(rx_d), .hit(rx_warn_d));
  can_err_cmp #(.W(CNT_W), .LIMIT(WARN_LVL), .INCLUSIVE(1'b0)) u_tx_warn_d (
    .value(tx_d), .hit(tx_warn_d));
  can_err_cmp #(.W(CNT_W), .LIMIT(PASS_LVL), .INCLUSIVE(1'b0)) u_rx_pass_d (
    .value(rx_d), .hit(rx_pass_d));

  assign level_rise = (rx_warn_d & ~rx_warn_o) |
                      (tx_warn_d & ~tx_warn_o) |
                      (rx_pass_d & ~rx_passive_o);

  always_comb begin
    st_set              = '0;
    st_set[CLR_ERRIF]   = rx_err_i | rx_ovf_i | level_rise;
    st_set[CLR_INVALID] = rx_err_i;
    st_set[CLR_OVERRUN] = rx_ovf_i;
  end

  can_err_sticky #(.N(NUM_STICKY)) u_flags (
    .clk(clk), .rst(rst), .set(st_set), .clr(flag_clr_i), .q(st_q));

  assign errif_o   = st_q[CLR_ERRIF];
  assign invalid_o = st_q[CLR_INVALID];
  assign overrun_o = st_q[CLR_OVERRUN];
endmodule

// File: rtl/can_err_status_chk.sv
module can_err_status_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_err_i,
  input logic             tx_err_i,
  input logic             rx_ovf_i,
  input logic             rx_ok_i,
  input logic             tx_ok_i,
  input logic [2:0]       flag_clr_i,
  input logic [CNT_W-1:0] rx_cnt_o,
  input logic [CNT_W-1:0] tx_cnt_o,
  input logic             rx_warn_o,
  input logic             tx_warn_o,
  input logic             rx_passive_o,
  input logic             invalid_o,
  input logic             overrun_o,
  input logic             errif_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_TX_STEP: assert property (@(posedge clk) disable iff (rst)
    tx_err_i && !tx_ok_i && tx_cnt_o != TOP |=> tx_cnt_o == CNT_W'($past(tx_cnt_o) + 1'b1)); // R2
  AST_RX_FLOOR: assert property (@(posedge clk) disable iff (rst)
    rx_ok_i && !rx_err_i && rx_cnt_o == '0 |=> rx_cnt_o == '0); // R3
  AST_TX_SATURATE: assert property (@(posedge clk) disable iff (rst)
    tx_err_i && tx_cnt_o == TOP |=> tx_cnt_o == TOP); // R4
  AST_PASSIVE_IMPLIES_WARN: assert property (@(posedge clk) disable iff (rst)
    rx_passive_o |-> rx_warn_o); // R8
  AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    invalid_o && !flag_clr_i[1] |=> invalid_o); // R9
  AST_TXWARN_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_warn_o) |-> errif_o); // R10
  AST_PASSIVE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_passive_o) |-> errif_o); // R10
  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flag_clr_i[2] && !rx_ovf_i |=> !overrun_o); // R11
endmodule

bind can_err_status can_err_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_err_i(rx_err_i), .tx_err_i(tx_err_i),
  .rx_ovf_i(rx_ovf_i), .rx_ok_i(rx_ok_i), .tx_ok_i(tx_ok_i),
  .flag_clr_i(flag_clr_i), .rx_cnt_o(rx_cnt_o), .tx_cnt_o(tx_cnt_o),
  .rx_warn_o(rx_warn_o), .tx_warn_o(tx_warn_o), .rx_passive_o(rx_passive_o),
  .invalid_o(invalid_o), .overrun_o(overrun_o), .errif_o(errif_o));

// File: tb/can_err_status_bench.sv
`timescale 1ns/1ps
module can_err_status_bench;
  logic clk = 1'b0;
  logic rst;
  logic rx_err, tx_err, rx_ovf, rx_ok, tx_ok;
  logic [2:0] clr;
  logic [7:0] rx_cnt, tx_cnt;
  logic rx_warn, tx_warn, rx_pass, invalid, overrun, errif;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_rx, m_tx;
  bit m_inv, m_ovr, m_irq;

  always #2 clk = ~clk;

  can_err_status u_can_err_status (
    .clk(clk), .rst(rst), .rx_err_i(rx_err), .tx_err_i(tx_err),
    .rx_ovf_i(rx_ovf), .rx_ok_i(rx_ok), .tx_ok_i(tx_ok), .flag_clr_i(clr),
    .rx_cnt_o(rx_cnt), .tx_cnt_o(tx_cnt), .rx_warn_o(rx_warn),
    .tx_warn_o(tx_warn), .rx_passive_o(rx_pass), .invalid_o(invalid),
    .overrun_o(overrun), .errif_o(errif));

  function automatic int next_cnt(int cur, bit inc, bit dec);
    if (inc && !dec) return (cur == 255) ? 255 : cur + 1;
    if (dec && !inc) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  function automatic bit rxw(int c);  return c >= 96;  endfunction
  function automatic bit txw(int c);  return c > 96;   endfunction
  function automatic bit rxp(int c);  return c > 127;  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 R4 R5 rx_cnt", rx_cnt, m_rx);
    chk("R2 R3 R4 R5 tx_cnt", tx_cnt, m_tx);
    chk("R7 rx_warn", rx_warn, rxw(m_rx));
    chk("R6 tx_warn", tx_warn, txw(m_tx));
    chk("R8 rx_passive", rx_pass, rxp(m_rx));
    chk("R9 invalid", invalid, m_inv);
    chk("R9 overrun", overrun, m_ovr);
    chk("R10 R11 errif", errif, m_irq);
  endtask

  // drive at a falling edge, update model, check at next falling edge
  task automatic step(bit re, bit te, bit ov, bit ro, bit to, logic [2:0] c);
    int nrx, ntx;
    bit rise;
    rx_err = re; tx_err = te; rx_ovf = ov; rx_ok = ro; tx_ok = to; clr = c;
    nrx = next_cnt(m_rx, re, ro);
    ntx = next_cnt(m_tx, te, to);
    rise = (rxw(nrx) && !rxw(m_rx)) || (txw(ntx) && !txw(m_tx)) ||
           (rxp(nrx) && !rxp(m_rx));
    m_irq = (re || ov || rise) ? 1'b1 : (c[0] ? 1'b0 : m_irq);
    m_inv = re ? 1'b1 : (c[1] ? 1'b0 : m_inv);
    m_ovr = ov ? 1'b1 : (c[2] ? 1'b0 : m_ovr);
    m_rx = nrx;
    m_tx = ntx;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd20517);
    rst = 1'b1; rx_err = 0; tx_err = 0; rx_ovf = 0; rx_ok = 0; tx_ok = 0; clr = '0;
    m_rx = 0; m_tx = 0; m_inv = 0; m_ovr = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check_all();
    rst = 1'b0;

    // R6 R10: transmit errors up to the warning crossing, errif only at 97
    for (int i = 0; i < 96; i++) step(0, 1, 0, 0, 0, 3'b000);
    chk("R10 no irq below tx warn", errif, 0);
    step(0, 1, 0, 0, 0, 3'b000);
    chk("R6 tx_warn at 97", tx_warn, 1);
    chk("R10 irq on tx warn rise", errif, 1);
    // R4: saturation
    for (int i = 0; i < 200; i++) step(0, 1, 0, 0, 0, 3'b000);
    chk("R4 tx saturated", tx_cnt, 255);
    // R5: simultaneous up and down
    step(0, 1, 0, 0, 1, 3'b000);
    step(1, 0, 0, 1, 0, 3'b001);
    chk("R5 rx unchanged", rx_cnt, 0);
    // R7 R8: receive errors through 96 and 128
    for (int i = 0; i < 140; i++) step(1, 0, 0, 0, 0, 3'b000);
    // R11: clear wins only without a set
    step(1, 0, 1, 0, 0, 3'b111);
    chk("R11 set wins invalid", invalid, 1);
    step(0, 0, 0, 0, 0, 3'b111);
    chk("R11 clear errif", errif, 0);
    chk("R11 clear overrun", overrun, 0);
    // R3: drain both counters below zero
    for (int i = 0; i < 300; i++) step(0, 0, 0, 1, 1, 3'b000);
    chk("R3 rx floor", rx_cnt, 0);
    chk("R3 tx floor", tx_cnt, 0);

    // random phases, biased toward errors then toward successes
    for (int ph = 0; ph < 6; ph++) begin
      int ebias = (ph % 2 == 0) ? 70 : 25;
      for (int i = 0; i < 600; i++) begin
        step(($urandom % 100) < ebias, ($urandom % 100) < ebias,
             ($urandom % 100) < 5,
             ($urandom % 100) < (100 - ebias), ($urandom % 100) < (100 - ebias),
             3'(($urandom % 100) < 10 ? $urandom : 0));
      end
    end

    // R1: reset mid-run
    rst = 1'b1;
    m_rx = 0; m_tx = 0; m_inv = 0; m_ovr = 0; m_irq = 0;
    @(negedge clk);
    check_all();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule